// File: doc/BRIEF.md
# Per-Pin Direction Configuration Array

This block sits between a tester's vector engine and its pin pads and decides, pin by pin, whether each of the tester's pins drives the device under test, listens to it, or alternates between the two. Each pin has a two-bit mode field in a configuration word. The field selects one of four modes: a fixed driver, a fixed receiver, a bidirectional pin whose direction is re-decided every cycle, or an idle pin. The configuration word is captured as a whole when a load strobe is high, and it keeps its value while the strobe is low.

Each cycle the block registers the stimulus vector. A driving pin then places the stimulus bit of its own index on its pad and raises its output enable. A listening pin keeps its enable low. At the next clock edge the pad value of a listening pin is sampled into the captured vector. Bits of the captured vector that belong to driving or idle pins read as zero, so a later comparison against expected device outputs does not see them. A bidirectional pin takes its direction from a polarity bit in the upper part of the same stimulus vector, located a fixed offset above the pin's own index. Pin i therefore follows stimulus bit i+POL_OFFSET.

The pads themselves are outside the block. They appear as separate output-value, output-enable and input-value vectors.

Top module: `pindir_array`

## Requirements
- R1: While reset is low and after it is released (before any load), every field holds the idle code 11. pad_oe, pad_out and cap_vec are all zero.
- R2: The field for pin i sits at cfg_word bits [2i+1:2i]. The word is taken on a rising edge with cfg_load high and takes effect from that edge onward. With cfg_load low, changes on cfg_word have no effect on any output.
- R3: Code 00 (drive): in the cycle after a stimulus vector is clocked in, pad_oe[i] is 1 and pad_out[i] equals stimulus bit i.
- R4: Code 01 (sense): pad_oe[i] and pad_out[i] are 0 whatever stimulus bit i is. cap_vec[i] shows pad_in[i] as sampled at the previous rising edge.
- R5: Code 10 (bidirectional) with polarity bit stim[i+POL_OFFSET] equal to 1: the pin drives exactly as in R3, and cap_vec[i] reads 0.
- R6: Code 10 with polarity bit 0: the pin listens exactly as in R4.
- R7: Code 11 (idle): pad_oe[i], pad_out[i] and cap_vec[i] are 0 whatever the stimulus and pad values are.
- R8: cap_vec[i] is 0 for a pin that was driving at the sampling edge.
- R9: Code 10 on a pin with i+POL_OFFSET >= NUM_PINS has no polarity source. Such a pin behaves as idle.
- R10: pad_out[i] is 0 whenever pad_oe[i] is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Vector clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Load strobe for the mode word |
| cfg_word | input | 192 | Two-bit mode field per pin |
| stim_vec | input | 96 | Stimulus vector: drive values, plus polarity bits in the upper part |
| pad_in | input | 96 | Values seen on the pads |
| pad_out | output | 96 | Values to drive on the pads |
| pad_oe | output | 96 | Pad output enables |
| cap_vec | output | 96 | Sampled device outputs, zero on non-listening pins |

## Verification
The bench goes after the polarity coupling. Patterns make stimulus bit i+48 differ from bit i. A design that took the direction from the pin's own bit, or from the wrong offset, would raise enables on listening pins. Pins in the upper half are set to the bidirectional code, and they must stay quiet: a design that wrapped the polarity index around would drive them. The bench also changes cfg_word with the strobe low and checks that the outputs still follow the old modes. Random pad values on driving pins catch a design that leaks driven pads into the captured vector.

// File: rtl/pindir_pkg.sv
// Package: shared mode encoding for the pin direction array.
// Assumes every consumer decodes a two-bit field per pin.
package pindir_pkg;

    typedef enum logic [1:0] {
        PM_DRIVE = 2'b00,
        PM_SENSE = 2'b01,
        PM_SWING = 2'b10,
        PM_IDLE  = 2'b11
    } pin_mode_e;

    localparam int MODE_W = 2;

endpackage

// File: rtl/pindir_vreg.sv
// Module: pindir_vreg
// A vector register with a load enable and a synchronous active-low reset.
// The reset value is all zeros or all ones, chosen by RST_ONES.
// Assumes rst_n is synchronous to clk.
module pindir_vreg #(
    parameter int W        = 8,
    parameter bit RST_ONES = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Hold or take the new value on each edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= {W{RST_ONES}};
        else if (en)
            q <= d;
    end

endmodule

// File: rtl/pindir_cell.sv
// Module: pindir_cell
// Combinational direction logic for one pin.
// It decodes the mode and the per-cycle polarity into a drive enable, a pad
// value, and the bit to be captured.
// Assumes HAS_POL is 0 when no polarity bit exists for this pin. In that case
// the bidirectional code acts as idle.
module pindir_cell
    import pindir_pkg::*;
#(
    parameter bit HAS_POL = 1'b1
) (
    input  pin_mode_e mode,
    input  logic      drv_bit,
    input  logic      pol_bit,
    input  logic      pad_in_bit,
    output logic      pad_out_bit,
    output logic      pad_oe_bit,
    output logic      cap_bit
);

    logic drive;
    logic listen;

    // Decide whether this pin drives or listens in the current cycle.
    always_comb begin
        drive  = 1'b0;
        listen = 1'b0;
        case (mode)
            PM_DRIVE: drive  = 1'b1;
            PM_SENSE: listen = 1'b1;
            PM_SWING: begin
                drive  = HAS_POL &&  pol_bit;
                listen = HAS_POL && !pol_bit;
            end
            default: ;
        endcase
    end

    // Pad value is gated by the enable, and the capture bit by listening.
    always_comb begin
        pad_oe_bit  = drive;
        pad_out_bit = drive & drv_bit;
        cap_bit     = listen & pad_in_bit;
    end

endmodule

// File: rtl/pindir_array.sv
// Module: pindir_array (top)
// Per-pin direction control for NUM_PINS tester pins.
// It holds the mode word, registers the stimulus vector, drives the pads
// and captures listening pins at each edge.
// Assumes POL_OFFSET < NUM_PINS. Pin i takes its bidirectional polarity from
// stimulus bit i+POL_OFFSET when that index exists.
module pindir_array
    import pindir_pkg::*;
#(
    parameter int NUM_PINS   = 96,
    parameter int POL_OFFSET = 48
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_load,
    input  logic [MODE_W*NUM_PINS-1:0]     cfg_word,
    input  logic [NUM_PINS-1:0]            stim_vec,
    input  logic [NUM_PINS-1:0]            pad_in,
    output logic [NUM_PINS-1:0]            pad_out,
    output logic [NUM_PINS-1:0]            pad_oe,
    output logic [NUM_PINS-1:0]            cap_vec
);

    localparam int CFG_W = MODE_W * NUM_PINS;

    logic [CFG_W-1:0]    cfg_q;
    logic [NUM_PINS-1:0] stim_q;
    logic [NUM_PINS-1:0] cap_d;

    // Mode word: resets to all idle, changes only under the load strobe.
    pindir_vreg #(.W(CFG_W), .RST_ONES(1'b1)) u_cfg (
        .clk(clk), .rst_n(rst_n), .en(cfg_load), .d(cfg_word), .q(cfg_q)
    );

    // Stimulus vector register: one vector per cycle.
    pindir_vreg #(.W(NUM_PINS), .RST_ONES(1'b0)) u_stim (
        .clk(clk), .rst_n(rst_n), .en(1'b1), .d(stim_vec), .q(stim_q)
    );

    // Capture register: samples listening pins every edge.
    pindir_vreg #(.W(NUM_PINS), .RST_ONES(1'b0)) u_cap (
        .clk(clk), .rst_n(rst_n), .en(1'b1), .d(cap_d), .q(cap_vec)
    );

    // One cell per pin. Pins without a polarity index get the idle variant.
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        if (i + POL_OFFSET < NUM_PINS) begin : g_pol
            pindir_cell #(.HAS_POL(1'b1)) u_cell (
                .mode       (pin_mode_e'(cfg_q[MODE_W*i +: MODE_W])),
                .drv_bit    (stim_q[i]),
                .pol_bit    (stim_q[i + POL_OFFSET]),
                .pad_in_bit (pad_in[i]),
                .pad_out_bit(pad_out[i]),
                .pad_oe_bit (pad_oe[i]),
                .cap_bit    (cap_d[i])
            );
        end else begin : g_nopol
            pindir_cell #(.HAS_POL(1'b0)) u_cell (
                .mode       (pin_mode_e'(cfg_q[MODE_W*i +: MODE_W])),
                .drv_bit    (stim_q[i]),
                .pol_bit    (1'b0),
                .pad_in_bit (pad_in[i]),
                .pad_out_bit(pad_out[i]),
                .pad_oe_bit (pad_oe[i]),
                .cap_bit    (cap_d[i])
            );
        end
    end

endmodule

// File: rtl/pindir_array_chk.sv
// Module: pindir_array_chk
// Property checker for pindir_array. It is attached with bind below.
// Assumes the default reset values of the array (all pins idle).
module pindir_array_chk #(
    parameter int NUM_PINS = 96
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cfg_load,
    input logic [2*NUM_PINS-1:0]   cfg_word,
    input logic [2*NUM_PINS-1:0]   cfg_q,
    input logic [NUM_PINS-1:0]     stim_vec,
    input logic [NUM_PINS-1:0]     pad_in,
    input logic [NUM_PINS-1:0]     pad_out,
    input logic [NUM_PINS-1:0]     pad_oe,
    input logic [NUM_PINS-1:0]     cap_vec
);

    logic [NUM_PINS-1:0] idle_mask;

    // Mark every pin whose stored field is the idle code.
    always_comb begin
        for (int k = 0; k < NUM_PINS; k++)
            idle_mask[k] = (cfg_q[2*k +: 2] == 2'b11);
    end

    // R10
    quiet_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & ~pad_oe) == '0);

    // R2
    cfg_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> cfg_q == $past(cfg_word));

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> $stable(cfg_q));

    // R7
    idle_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & idle_mask) == '0);

    // R8
    no_self_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_vec & $past(pad_oe)) == '0);

    // R4
    cap_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_vec & ~$past(pad_in)) == '0);

    // R3
    drive_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out ^ $past(stim_vec)) & pad_oe) == '0);

endmodule

bind pindir_array pindir_array_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_word(cfg_word),
    .cfg_q(cfg_q), .stim_vec(stim_vec), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .cap_vec(cap_vec)
);

// File: tb/pindir_array_test.sv
// Bench: sweeps per-pin mode assignments over many stimulus and pad patterns.
// The expected results are computed from the mode codes.
module pindir_array_test;

    localparam int CLK_PERIOD = 10;
    localparam int NP  = 96;
    localparam int OFS = 48;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_load = 1'b0;
    logic [2*NP-1:0] cfg_word = '0;
    logic [NP-1:0]   stim_vec = '0;
    logic [NP-1:0]   pad_in = '0;
    logic [NP-1:0]   pad_out, pad_oe, cap_vec;

    int total = 0;
    int bad   = 0;
    logic [1:0] codes [NP];

    always #(CLK_PERIOD/2) clk = ~clk;

    pindir_array uut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_word(cfg_word),
        .stim_vec(stim_vec), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .cap_vec(cap_vec)
    );

    task automatic chk(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [NP-1:0] rnd96();
        return {$urandom(), $urandom(), $urandom()};
    endfunction

    // Build the mode codes of a round and load them.
    task automatic load_round(input int r);
        logic [2*NP-1:0] w;
        for (int i = 0; i < NP; i++) begin
            codes[i] = 2'((i + r + i / 7) % 4);
            w[2*i +: 2] = codes[i];
        end
        @(negedge clk);
        cfg_word = w;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        cfg_word = ~w;   // R2: changes with the strobe low must be ignored
    endtask

    // One vector: check the pads, then the capture one edge later.
    task automatic run_step(input logic [NP-1:0] stim, input logic [NP-1:0] pin);
        logic [NP-1:0] drv_m, sen_m, bdrv_m, blis_m, idle_m, nopol_m;
        drv_m = '0; sen_m = '0; bdrv_m = '0; blis_m = '0; idle_m = '0; nopol_m = '0;
        for (int i = 0; i < NP; i++) begin
            case (codes[i])
                2'b00: drv_m[i] = 1'b1;
                2'b01: sen_m[i] = 1'b1;
                2'b10: begin
                    if (i + OFS >= NP) nopol_m[i] = 1'b1;
                    else if (stim[i + OFS]) bdrv_m[i] = 1'b1;
                    else blis_m[i] = 1'b1;
                end
                default: idle_m[i] = 1'b1;
            endcase
        end
        @(negedge clk);
        stim_vec = stim;
        @(negedge clk);
        chk("R3 drive oe", pad_oe & drv_m, drv_m);
        chk("R3 drive value", pad_out & drv_m, stim & drv_m);
        chk("R4 sense oe", pad_oe & sen_m, '0);
        chk("R4 sense out", pad_out & sen_m, '0);
        chk("R5 bidir drive oe", pad_oe & bdrv_m, bdrv_m);
        chk("R5 bidir drive value", pad_out & bdrv_m, stim & bdrv_m);
        chk("R6 bidir listen oe", pad_oe & blis_m, '0);
        chk("R7 idle oe/out", (pad_oe | pad_out) & idle_m, '0);
        chk("R9 no-polarity oe/out", (pad_oe | pad_out) & nopol_m, '0);
        chk("R10 out gated", pad_out & ~pad_oe, '0);
        pad_in = pin;
        @(negedge clk);
        chk("R4 sense capture", cap_vec & sen_m, pin & sen_m);
        chk("R6 bidir capture", cap_vec & blis_m, pin & blis_m);
        chk("R5 R8 no capture on driving", cap_vec & (drv_m | bdrv_m), '0);
        chk("R7 idle capture", cap_vec & idle_m, '0);
        chk("R9 no-polarity capture", cap_vec & nopol_m, '0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        stim_vec = rnd96();
        pad_in   = rnd96();
        cfg_word = '0;
        cfg_load = 1'b1;          // must not load while in reset
        repeat (3) @(negedge clk);
        chk("R1 reset oe", pad_oe, '0);
        chk("R1 reset out", pad_out, '0);
        chk("R1 reset cap", cap_vec, '0);
        cfg_load = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle after reset oe", pad_oe, '0);
        chk("R1 idle after reset cap", cap_vec, '0);

        for (int r = 0; r < 4; r++) begin
            load_round(r);
            run_step('0, '1);
            run_step('1, '1);
            run_step({{OFS{1'b1}}, {(NP-OFS){1'b0}}}, rnd96());
            run_step({{OFS{1'b0}}, {(NP-OFS){1'b1}}}, rnd96());
            for (int s = 0; s < 6; s++)
                run_step(rnd96(), rnd96());
        end
        // R2: field order check, only pin 5 drives
        for (int i = 0; i < NP; i++) codes[i] = (i == 5) ? 2'b00 : 2'b11;
        @(negedge clk);
        cfg_word = '1;
        cfg_word[11:10] = 2'b00;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        run_step('1, '1);
        chk("R2 field position", pad_oe, NP'(1) << 5);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule